// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside the ECC decoder of a DRAM controller and keeps a record of the errors it reports. The decoder supplies single-cycle pulses, one for correctable and one for uncorrectable errors, and the address that failed. The block counts each class on its own and keeps one address for each class. For uncorrectable errors that is the first address since the last clear. For correctable errors it is the most recent one. It raises a level interrupt for any error class that software has enabled.

Software reaches the block through a simple 32-bit register port with word-aligned byte offsets. Reads are combinational from the offset. A write takes effect on the clock edge where the write enable is high. A key register guards every write other than a write to the key itself. Software writes the magic key, performs one write, and locks the block again by writing any other value. The configuration register holds an ECC-enable flag and a DRAM-type flag, and both drive outputs to the rest of the controller.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the block is locked, and reads return 0 from the key (0x00), control/status (0x50) and both address registers (0x58, 0x5C). The configuration register (0x04) reads the reset parameter, which defaults to 0x0000_0080, and irq_o is low.
- R2: A write of 0xFC600309 to offset 0x00 unlocks the block, and a write of any other value locks it. Bit 0 of a read from 0x00 shows 1 while unlocked and 0 while locked.
- R3: While the block is locked, writes to 0x04 and 0x50 have no effect. Reads work whether the block is locked or unlocked.
- R4: The control/status register at 0x50 is laid out as follows:
  - bit 31 is the clear control;
  - bits [23:16] hold the correctable count;
  - bits [15:12] hold the uncorrectable count;
  - bits [1:0] are the interrupt enables;
  - all other bits read 0.
  Each accepted pulse adds one to the count of its class. Pulses of both classes can arrive in the same cycle.
- R5: The correctable count stops at 255 and the uncorrectable count stops at 15. Neither wraps to 0.
- R6: Offset 0x58 holds the address of the first uncorrectable error accepted since the last clear. Later uncorrectable errors do not change it.
- R7: Offset 0x5C holds the address of the most recent accepted correctable error.
- R8: While bit 31 of 0x50 is 1, both counts and both addresses read 0 and error pulses are dropped.
  - A pulse that arrives in the cycle of the write that releases bit 31 is counted.
  - A pulse that arrives in the cycle of the write that sets bit 31 is dropped.
- R9: irq_o is high while enable bit 0 is set and the correctable count is nonzero, or while enable bit 1 is set and the uncorrectable count is nonzero. It rises in the cycle after the pulse and stays high until the count is cleared or the enable bit is removed.
- R10: Configuration bit 7 drives ecc_en_o and bit 4 drives ddr4_o, where 1 means DDR4 and 0 means DDR3. The other configuration bits read 0. Error pulses are dropped while bit 7 is 0.
- R11: Software cannot write the address registers. A read from any offset that is not in the map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Byte offset for register reads and writes |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| corr_err_i | input | 1 | One-cycle pulse for a correctable error |
| uncorr_err_i | input | 1 | One-cycle pulse for an uncorrectable error |
| err_addr_i | input | ERR_AW | Address of the failing access |
| ecc_en_o | output | 1 | ECC-enable flag from the configuration register |
| ddr4_o | output | 1 | DRAM type flag: 1 means DDR4, 0 means DDR3 |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The hardest cases to reach from the ports are the two edge cases of the clear control. In one, a pulse lands in the same cycle as the write that releases bit 31. In the other, a pulse lands in the same cycle as the write that sets it. The bench drives the error pulse and the register write in one combined step, so both land on the same clock edge. It then reads the counts back to see whether the pulse was kept or dropped. Saturation is reached by issuing more than 255 back-to-back pulses of both classes. The first-address and last-address rules are checked in the same run.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned DW     = 32;
  localparam int unsigned CCNT_W = 8;
  localparam int unsigned UCNT_W = 4;

  localparam logic [REG_AW-1:0] OFS_KEY   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CFG   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h50;
  localparam logic [REG_AW-1:0] OFS_UADDR = 8'h58;
  localparam logic [REG_AW-1:0] OFS_CADDR = 8'h5C;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int unsigned CLR_BIT   = 31;
  localparam int unsigned CCNT_LSB  = 16;
  localparam int unsigned UCNT_LSB  = 12;
  localparam int unsigned ECC_BIT   = 7;
  localparam int unsigned DDR4_BIT  = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_KEY, SEL_CFG, SEL_CTRL, SEL_UADDR, SEL_CADDR
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(logic [REG_AW-1:0] a);
    logic [REG_AW-1:0] w;
    w = {a[REG_AW-1:2], 2'b00};
    case (w)
      OFS_KEY:   return SEL_KEY;
      OFS_CFG:   return SEL_CFG;
      OFS_CTRL:  return SEL_CTRL;
      OFS_UADDR: return SEL_UADDR;
      OFS_CADDR: return SEL_CADDR;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ecc_log_lock.sv
module ecc_log_lock
  import ecc_log_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [DW-1:0] key_data_i,
  output logic          unlocked_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       unlocked_q <= 1'b0;
    else if (key_wr_i) unlocked_q <= (key_data_i == UNLOCK_KEY);
  end

  assign unlocked_o = unlocked_q;

  // R2
  key_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && key_data_i == UNLOCK_KEY |=> unlocked_o);
  // R2
  key_shut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_i && key_data_i != UNLOCK_KEY |=> !unlocked_o);
  // R2
  key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr_i |=> $stable(unlocked_o));
endmodule

// File: rtl/ecc_log_sat_cnt.sv
module ecc_log_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && cnt_o == MAX |=> cnt_o == MAX);
  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && cnt_o != MAX |=> cnt_o == $past(cnt_o) + 1'b1);
  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/ecc_log_addr_cap.sv
module ecc_log_addr_cap #(
  parameter int unsigned AW         = 32,
  parameter bit          KEEP_FIRST = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hit_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  generate
    if (KEEP_FIRST) begin : g_first
      logic held_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_q <= '0;
          held_q <= 1'b0;
        end else if (clr_i) begin
          addr_q <= '0;
          held_q <= 1'b0;
        end else if (hit_i && !held_q) begin
          addr_q <= addr_i;
          held_q <= 1'b1;
        end
      end
      // R6
      first_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held_q && !clr_i |=> $stable(addr_o));
    end else begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    addr_q <= '0;
        else if (clr_i) addr_q <= '0;
        else if (hit_i) addr_q <= addr_i;
      end
      // R7
      last_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i && !clr_i |=> addr_o == $past(addr_i));
    end
  endgenerate

  assign addr_o = addr_q;
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int unsigned   ERR_AW  = 32,
  parameter logic [DW-1:0] CFG_RST = 32'h0000_0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              corr_err_i,
  input  logic              uncorr_err_i,
  input  logic [ERR_AW-1:0] err_addr_i,
  output logic              ecc_en_o,
  output logic              ddr4_o,
  output logic              irq_o
);
  reg_sel_e sel;
  logic unlocked, wr_ok, cfg_wr, ctrl_wr;
  logic ecc_q, ddr4_q, clr_q, clr_eff;
  logic [1:0] irq_en_q;
  logic c_hit, u_hit;
  logic [CCNT_W-1:0] ccnt;
  logic [UCNT_W-1:0] ucnt;
  logic [ERR_AW-1:0] uaddr, caddr;

  assign sel     = decode_sel(reg_addr_i);
  assign wr_ok   = reg_we_i && unlocked;
  assign cfg_wr  = wr_ok && sel == SEL_CFG;
  assign ctrl_wr = wr_ok && sel == SEL_CTRL;

  ecc_log_lock u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (reg_we_i && sel == SEL_KEY),
    .key_data_i (reg_wdata_i),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_q  <= CFG_RST[ECC_BIT];
      ddr4_q <= CFG_RST[DDR4_BIT];
    end else if (cfg_wr) begin
      ecc_q  <= reg_wdata_i[ECC_BIT];
      ddr4_q <= reg_wdata_i[DDR4_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q    <= 1'b0;
      irq_en_q <= 2'b00;
    end else if (ctrl_wr) begin
      clr_q    <= reg_wdata_i[CLR_BIT];
      irq_en_q <= reg_wdata_i[1:0];
    end
  end

  // clear as seen after this cycle's write: release admits, set drops
  assign clr_eff = ctrl_wr ? reg_wdata_i[CLR_BIT] : clr_q;
  assign c_hit   = corr_err_i   && ecc_q && !clr_eff;
  assign u_hit   = uncorr_err_i && ecc_q && !clr_eff;

  ecc_log_sat_cnt #(.W(CCNT_W)) u_ccnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_eff), .inc_i (c_hit), .cnt_o (ccnt)
  );
  ecc_log_sat_cnt #(.W(UCNT_W)) u_ucnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_eff), .inc_i (u_hit), .cnt_o (ucnt)
  );

  ecc_log_addr_cap #(.AW(ERR_AW), .KEEP_FIRST(1'b1)) u_uaddr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_eff), .hit_i (u_hit),
    .addr_i (err_addr_i), .addr_o (uaddr)
  );
  ecc_log_addr_cap #(.AW(ERR_AW), .KEEP_FIRST(1'b0)) u_caddr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr_eff), .hit_i (c_hit),
    .addr_i (err_addr_i), .addr_o (caddr)
  );

  assign irq_o    = (irq_en_q[0] && ccnt != '0) || (irq_en_q[1] && ucnt != '0);
  assign ecc_en_o = ecc_q;
  assign ddr4_o   = ddr4_q;

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_KEY:  reg_rdata_o[0] = unlocked;
      SEL_CFG: begin
        reg_rdata_o[ECC_BIT]  = ecc_q;
        reg_rdata_o[DDR4_BIT] = ddr4_q;
      end
      SEL_CTRL: begin
        reg_rdata_o[CLR_BIT]                   = clr_q;
        reg_rdata_o[CCNT_LSB +: CCNT_W]        = ccnt;
        reg_rdata_o[UCNT_LSB +: UCNT_W]        = ucnt;
        reg_rdata_o[1:0]                       = irq_en_q;
      end
      SEL_UADDR: reg_rdata_o = DW'(uaddr);
      SEL_CADDR: reg_rdata_o = DW'(caddr);
      default:   reg_rdata_o = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{CFG_RST};

  // R3
  locked_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !unlocked && sel == SEL_CFG |=> $stable({ecc_en_o, ddr4_o}));
  // R3
  locked_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !unlocked && sel == SEL_CTRL |=> $stable({clr_q, irq_en_q}));
  // R10
  ecc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ecc_en_o && !clr_eff |=> $stable(ccnt) && $stable(ucnt));
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_q && !ctrl_wr |=> irq_o);
endmodule

// File: tb/ecc_err_log_test.sv
`timescale 1ns/100ps
module ecc_err_log_test;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        corr = 1'b0, uncorr = 1'b0;
  logic [31:0] err_addr = '0;
  logic        ecc_en, ddr4, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_log uut (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_addr_i (reg_addr), .reg_we_i (reg_we), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .corr_err_i (corr), .uncorr_err_i (uncorr), .err_addr_i (err_addr),
    .ecc_en_o (ecc_en), .ddr4_o (ddr4), .irq_o (irq)
  );

  typedef struct packed {
    logic        c;
    logic        u;
    logic [31:0] a;
    logic [7:0]  ec;
    logic [3:0]  eu;
    logic [31:0] eua;
    logic [31:0] eca;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 32'h0000_1000, 8'd1, 4'd0, 32'h0,         32'h0000_1000},
    '{1'b0, 1'b1, 32'h0000_2000, 8'd1, 4'd1, 32'h0000_2000, 32'h0000_1000},
    '{1'b1, 1'b1, 32'h0000_3000, 8'd2, 4'd2, 32'h0000_2000, 32'h0000_3000},
    '{1'b0, 1'b0, 32'h0000_4000, 8'd2, 4'd2, 32'h0000_2000, 32'h0000_3000},
    '{1'b1, 1'b0, 32'h0000_5004, 8'd3, 4'd2, 32'h0000_2000, 32'h0000_5004},
    '{1'b0, 1'b1, 32'h0000_6008, 8'd3, 4'd3, 32'h0000_2000, 32'h0000_5004}
  };

  function automatic logic [31:0] ctrl_val(logic clr, logic [7:0] c, logic [3:0] u, logic [1:0] en);
    return {clr, 7'b0, c, u, 10'b0, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic c, logic u, logic [31:0] ea);
    reg_we = we; reg_addr = a; reg_wdata = d;
    corr = c; uncorr = u; err_addr = ea;
    @(posedge clk); #1;
    reg_we = 1'b0; corr = 1'b0; uncorr = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic unlocked_wr(logic [7:0] a, logic [31:0] d);
    wr(8'h00, KEY); wr(a, d); wr(8'h00, ~KEY);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(8'h00, v); chk("R1 key", v, 32'h0);
    rd(8'h04, v); chk("R1 cfg", v, 32'h80);
    rd(8'h50, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h58, v); chk("R1 uaddr", v, 32'h0);
    rd(8'h5C, v); chk("R1 caddr", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 key unlock / relock
    wr(8'h00, KEY);  rd(8'h00, v); chk("R2 unlock", v, 32'h1);
    wr(8'h00, ~KEY); rd(8'h00, v); chk("R2 relock", v, 32'h0);
    wr(8'h00, KEY);  wr(8'h00, 32'h1234_5678); rd(8'h00, v); chk("R2 other value", v, 32'h0);

    // R3 locked writes ignored
    wr(8'h04, 32'h0000_0010); rd(8'h04, v); chk("R3 cfg locked", v, 32'h80);
    wr(8'h50, 32'h0000_0003); rd(8'h50, v); chk("R3 ctrl locked", v, 32'h0);

    // prepare: enables on, clear pulse
    unlocked_wr(8'h50, 32'h8000_0003);
    unlocked_wr(8'h50, 32'h0000_0003);

    // R4 R6 R7 vector walk
    foreach (VECS[i]) begin
      step(1'b0, 8'h00, 32'h0, VECS[i].c, VECS[i].u, VECS[i].a);
      rd(8'h50, v); chk("R4 counts", v, ctrl_val(1'b0, VECS[i].ec, VECS[i].eu, 2'b11));
      rd(8'h58, v); chk("R6 first uaddr", v, VECS[i].eua);
      rd(8'h5C, v); chk("R7 last caddr", v, VECS[i].eca);
    end
    chk("R9 irq both", {31'b0, irq}, 32'h1);

    // R11 address registers read-only, unmapped reads zero
    unlocked_wr(8'h58, 32'hDEAD_BEEF);
    rd(8'h58, v); chk("R11 uaddr ro", v, 32'h0000_2000);
    unlocked_wr(8'h5C, 32'hDEAD_BEEF);
    rd(8'h5C, v); chk("R11 caddr ro", v, 32'h0000_5004);
    rd(8'h08, v); chk("R11 unmapped", v, 32'h0);

    // R8 clear held: counts and addresses zero, pulses dropped
    wr(8'h00, KEY);
    wr(8'h50, 32'h8000_0003);
    rd(8'h50, v); chk("R8 clear counts", v, ctrl_val(1'b1, 8'd0, 4'd0, 2'b11));
    rd(8'h58, v); chk("R8 clear uaddr", v, 32'h0);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 32'h77);
    rd(8'h50, v); chk("R8 pulse while held", v, ctrl_val(1'b1, 8'd0, 4'd0, 2'b11));
    // R8 pulse on release cycle counted
    step(1'b1, 8'h50, 32'h0000_0003, 1'b1, 1'b1, 32'h88);
    rd(8'h50, v); chk("R8 release same cycle", v, ctrl_val(1'b0, 8'd1, 4'd1, 2'b11));
    rd(8'h58, v); chk("R8 release uaddr", v, 32'h88);
    // R8 pulse on set cycle dropped
    step(1'b1, 8'h50, 32'h8000_0003, 1'b1, 1'b0, 32'h99);
    rd(8'h50, v); chk("R8 set same cycle", v, ctrl_val(1'b1, 8'd0, 4'd0, 2'b11));
    wr(8'h50, 32'h0000_0003);

    // R5 saturation; R6/R7 first vs last under long run
    for (int i = 0; i < 260; i++)
      step(1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 32'h100 + i);
    rd(8'h50, v); chk("R5 saturate", v, ctrl_val(1'b0, 8'd255, 4'd15, 2'b11));
    rd(8'h58, v); chk("R6 first of run", v, 32'h100);
    rd(8'h5C, v); chk("R7 last of run", v, 32'h100 + 259);

    // R9 enables per class
    wr(8'h50, 32'h8000_0002); wr(8'h50, 32'h0000_0002);
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 32'h10);
    chk("R9 corr masked", {31'b0, irq}, 32'h0);
    step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1, 32'h20);
    chk("R9 uncorr enabled", {31'b0, irq}, 32'h1);
    wr(8'h50, 32'h0000_0000);
    chk("R9 enable removed", {31'b0, irq}, 32'h0);

    // R10 config bits and ECC-off gating
    wr(8'h50, 32'h8000_0000); wr(8'h50, 32'h0);
    wr(8'h04, 32'hFFFF_FF10);
    rd(8'h04, v); chk("R10 cfg readback", v, 32'h10);
    chk("R10 outputs", {30'b0, ecc_en, ddr4}, 32'h1);
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b1, 32'h30);
    rd(8'h50, v); chk("R10 ecc off drops", v, ctrl_val(1'b0, 8'd0, 4'd0, 2'b00));
    wr(8'h04, 32'h0000_0080);
    chk("R10 outputs ddr3", {30'b0, ecc_en, ddr4}, 32'h2);
    step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0, 32'h40);
    rd(8'h50, v); chk("R10 ecc on counts", v, ctrl_val(1'b0, 8'd1, 4'd0, 2'b00));
    wr(8'h00, ~KEY);
    rd(8'h50, v); chk("R3 read while locked", v, ctrl_val(1'b0, 8'd1, 4'd0, 2'b00));

    summary();
  end
endmodule